// File: doc/BRIEF.md
# Multi-Port Issue Scheduler

This block is the waiting room between the in-order front end and the execution units. Micro-operations arrive through an allocate port. Each one carries two source tags, each with a ready flag, a destination tag, a program sequence number and the index of the execution port it must run on. An entry stays in the station until both of its sources are available and its port is not busy. At that point the entry may be issued, and it leaves the station.

Every cycle, each of the five execution ports gets at most one entry, so up to five operations can leave in the same cycle. Program order plays no part in the choice. When several entries compete for one port, the winner is approximately the oldest. Each entry has a small saturating age counter, and an entry whose last missing source arrived on the writeback bus in the previous cycle gets precedence over the others. This lets a dependent operation issue immediately after the result it was waiting for.

Result tags arrive on a single writeback bus and wake matching sources. A flush input removes every entry that is younger than a given sequence number, so the station can recover from a mispredicted branch.

Top module: `rs_sched`

## Requirements
- R1: After reset the station is empty. No `issue_valid` bit is set and `alloc_ready` is high.
- R2: An entry is offered on issue port p (p = `alloc_port` value, 0 to 4) only when both source ready flags are set and `port_busy[p]` is low. `issue_valid[p]` and the destination tag on `issue_dst[p*6 +: 6]` are valid in the same cycle that these conditions hold.
- R3: Each port issues at most one entry per cycle. All five ports can issue in the same cycle.
- R4: A `wb_tag` that matches a waiting source marks that source ready at the next clock edge. The entry can then issue in the following cycle, but not in the cycle of the writeback. A non-matching tag wakes nothing. A matching writeback in the allocation cycle is also captured.
- R5: An issued entry leaves the station at the clock edge of its issue cycle and is never offered again.
- R6: Among competing ready entries on one port, the one with the larger age counter wins. The counter is 0 on allocation and increments each cycle, saturating at 2^AGEW-1. Equal ages fall to the lowest slot. Slots are filled lowest-free-first.
- R7: An entry whose last missing source was woken by the writeback bus wins its port in the next cycle over any entry that was not just woken, whatever the ages.
- R8: When all slots are occupied, `alloc_ready` is low and an allocation attempt stores nothing.
- R9: While `flush_valid` is high, every entry whose sequence number is younger than `flush_seq` is removed and does not issue in that cycle. An entry is younger when (seq - flush_seq) mod 64 is nonzero and below 32. Older and equal entries stay. `alloc_ready` is low during a flush.
- R10: An entry that is ready while its port is busy remains in the station and issues once the port is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_port | input | 3 | Execution port index, 0 to 4 |
| alloc_src0_tag | input | 6 | First source tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1_tag | input | 6 | Second source tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| alloc_dst | input | 6 | Destination tag |
| alloc_seq | input | 6 | Program sequence number |
| alloc_ready | output | 1 | A slot is free and no flush is active |
| wb_valid | input | 1 | Writeback tag valid |
| wb_tag | input | 6 | Produced result tag |
| flush_valid | input | 1 | Remove younger entries |
| flush_seq | input | 6 | Flush boundary sequence number |
| port_busy | input | 5 | Per-port busy, bit p for port p |
| issue_valid | output | 5 | Per-port issue strobe |
| issue_dst | output | 30 | Destination tag of each issued entry, port p at bits p*6 +: 6 |

## Verification
The bench keeps the default of 16 slots and overrides the age counter width to 2 bits. With that width, entries saturate after three waiting cycles. This brings the tie-break to the lowest slot within reach: a younger entry that sits in a lower slot can be shown to win once both entries have saturated. With 16 slots the full condition is reached in sixteen allocations. The bench can then drain the whole station in a single sequence and confirm that a refused allocation never reappears.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NPORTS = 5;
  localparam int PORTW  = $clog2(NPORTS);
  localparam int TAGW   = 6;
  localparam int SEQW   = 6;

  typedef struct packed {
    logic [PORTW-1:0] port;
    logic [TAGW-1:0]  s0_tag;
    logic             s0_rdy;
    logic [TAGW-1:0]  s1_tag;
    logic             s1_rdy;
    logic [TAGW-1:0]  dst;
    logic [SEQW-1:0]  seq;
  } uop_t;

  // a is younger than b under modular sequence arithmetic
  function automatic logic seq_younger(input logic [SEQW-1:0] a,
                                       input logic [SEQW-1:0] b);
    logic [SEQW-1:0] diff;
    diff = a - b;
    return (diff != '0) && !diff[SEQW-1];
  endfunction
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] used,
  output logic               any_free,
  output logic [ENTRIES-1:0] pick
);
  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!used[i] && !any_free) begin
        pick[i]  = 1'b1;
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int AGEW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  uop_t             load_uop,
  input  logic             wb_valid,
  input  logic [TAGW-1:0]  wb_tag,
  input  logic             flush_valid,
  input  logic [SEQW-1:0]  flush_seq,
  input  logic             grant,
  output logic             valid,
  output logic             req,
  output logic             hot,
  output logic [AGEW-1:0]  age,
  output logic [PORTW-1:0] port,
  output logic [TAGW-1:0]  dst
);
  localparam logic [AGEW-1:0] AGE_MAX = '1;

  logic            valid_q, valid_n;
  logic            hot_q, hot_n;
  logic [AGEW-1:0] age_q, age_n;
  uop_t            uop_q, uop_n;
  logic            kill, wake0, wake1, upd_en;

  always_comb begin
    kill    = flush_valid && seq_younger(uop_q.seq, flush_seq);
    req     = valid_q && uop_q.s0_rdy && uop_q.s1_rdy && !kill;
    valid_n = valid_q;
    uop_n   = uop_q;
    age_n   = age_q;
    hot_n   = 1'b0;
    wake0   = 1'b0;
    wake1   = 1'b0;
    if (load) begin
      wake0        = wb_valid && !load_uop.s0_rdy && (wb_tag == load_uop.s0_tag);
      wake1        = wb_valid && !load_uop.s1_rdy && (wb_tag == load_uop.s1_tag);
      uop_n        = load_uop;
      uop_n.s0_rdy = load_uop.s0_rdy | wake0;
      uop_n.s1_rdy = load_uop.s1_rdy | wake1;
      valid_n      = 1'b1;
      age_n        = '0;
      hot_n        = (wake0 | wake1) && uop_n.s0_rdy && uop_n.s1_rdy;
    end else if (valid_q) begin
      if (grant || kill) begin
        valid_n = 1'b0;
      end else begin
        wake0        = wb_valid && !uop_q.s0_rdy && (wb_tag == uop_q.s0_tag);
        wake1        = wb_valid && !uop_q.s1_rdy && (wb_tag == uop_q.s1_tag);
        uop_n.s0_rdy = uop_q.s0_rdy | wake0;
        uop_n.s1_rdy = uop_q.s1_rdy | wake1;
        if (age_q != AGE_MAX) age_n = age_q + 1'b1;
        hot_n        = (wake0 | wake1) && uop_n.s0_rdy && uop_n.s1_rdy;
      end
    end
    upd_en = load | valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hot_q   <= 1'b0;
      age_q   <= '0;
      uop_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_n;
      hot_q   <= hot_n;
      age_q   <= age_n;
      uop_q   <= uop_n;
    end
  end

  assign valid = valid_q;
  assign hot   = hot_q;
  assign age   = age_q;
  assign port  = uop_q.port;
  assign dst   = uop_q.dst;

  // R2
  grant_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (valid_q && uop_q.s0_rdy && uop_q.s1_rdy));
  // R5
  leave_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && grant) |=> !valid_q);
  // R9
  flush_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && kill) |=> !valid_q);
  // R4
  wake_src0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !grant && !kill && wb_valid && !uop_q.s0_rdy && wb_tag == uop_q.s0_tag)
      |=> (valid_q && uop_q.s0_rdy));
  // R6
  age_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !load && !grant && !kill && age_q == AGE_MAX) |=> (age_q == AGE_MAX));
endmodule

// File: rtl/rs_port_pick.sv
module rs_port_pick
  import rs_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AGEW    = 4,
  parameter int PORT_ID = 0,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            req,
  input  logic [ENTRIES-1:0][PORTW-1:0] port_of,
  input  logic [ENTRIES-1:0]            hot,
  input  logic [ENTRIES-1:0][AGEW-1:0]  age,
  input  logic                          busy,
  output logic [ENTRIES-1:0]            grant,
  output logic                          any,
  output logic [IDXW-1:0]               idx
);
  logic [AGEW:0] best_key, key;

  always_comb begin
    any      = 1'b0;
    idx      = '0;
    best_key = '0;
    key      = '0;
    grant    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      key = {hot[i], age[i]};
      if (req[i] && !busy && (port_of[i] == PORTW'(PORT_ID))) begin
        if (!any || (key > best_key)) begin
          any      = 1'b1;
          best_key = key;
          idx      = IDXW'(i);
        end
      end
    end
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AGEW    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_valid,
  input  logic [PORTW-1:0]       alloc_port,
  input  logic [TAGW-1:0]        alloc_src0_tag,
  input  logic                   alloc_src0_rdy,
  input  logic [TAGW-1:0]        alloc_src1_tag,
  input  logic                   alloc_src1_rdy,
  input  logic [TAGW-1:0]        alloc_dst,
  input  logic [SEQW-1:0]        alloc_seq,
  output logic                   alloc_ready,
  input  logic                   wb_valid,
  input  logic [TAGW-1:0]        wb_tag,
  input  logic                   flush_valid,
  input  logic [SEQW-1:0]        flush_seq,
  input  logic [NPORTS-1:0]      port_busy,
  output logic [NPORTS-1:0]      issue_valid,
  output logic [NPORTS*TAGW-1:0] issue_dst
);
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]              ent_valid, ent_req, ent_hot, ent_grant, load_sel;
  logic [ENTRIES-1:0][PORTW-1:0]   ent_port;
  logic [ENTRIES-1:0][AGEW-1:0]    ent_age;
  logic [ENTRIES-1:0][TAGW-1:0]    ent_dst;
  logic [NPORTS-1:0][ENTRIES-1:0]  port_gnt;
  logic [NPORTS-1:0][IDXW-1:0]     port_idx;
  logic [NPORTS-1:0]               port_any;
  logic                            any_free, alloc_fire;
  uop_t                            new_uop;

  rs_free_pick #(.ENTRIES(ENTRIES)) u_free (
    .used     (ent_valid),
    .any_free (any_free),
    .pick     (load_sel)
  );

  always_comb begin
    alloc_ready    = any_free && !flush_valid;
    alloc_fire     = alloc_valid && alloc_ready;
    new_uop.port   = alloc_port;
    new_uop.s0_tag = alloc_src0_tag;
    new_uop.s0_rdy = alloc_src0_rdy;
    new_uop.s1_tag = alloc_src1_tag;
    new_uop.s1_rdy = alloc_src1_rdy;
    new_uop.dst    = alloc_dst;
    new_uop.seq    = alloc_seq;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    rs_entry #(.AGEW(AGEW)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (alloc_fire && load_sel[i]),
      .load_uop    (new_uop),
      .wb_valid    (wb_valid),
      .wb_tag      (wb_tag),
      .flush_valid (flush_valid),
      .flush_seq   (flush_seq),
      .grant       (ent_grant[i]),
      .valid       (ent_valid[i]),
      .req         (ent_req[i]),
      .hot         (ent_hot[i]),
      .age         (ent_age[i]),
      .port        (ent_port[i]),
      .dst         (ent_dst[i])
    );
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rs_port_pick #(.ENTRIES(ENTRIES), .AGEW(AGEW), .PORT_ID(p)) u_pick (
      .req     (ent_req),
      .port_of (ent_port),
      .hot     (ent_hot),
      .age     (ent_age),
      .busy    (port_busy[p]),
      .grant   (port_gnt[p]),
      .any     (port_any[p]),
      .idx     (port_idx[p])
    );

    // R2
    busy_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_busy[p] |-> !issue_valid[p]);
    // R3
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_gnt[p]));
  end

  always_comb begin
    ent_grant = '0;
    for (int p = 0; p < NPORTS; p++) begin
      ent_grant = ent_grant | port_gnt[p];
      issue_valid[p]              = port_any[p];
      issue_dst[p*TAGW +: TAGW]   = ent_dst[port_idx[p]];
    end
  end

  // R8
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_valid) |-> !alloc_ready);
  // R9
  flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !alloc_fire);
endmodule

// File: tb/rs_sched_test.sv
module rs_sched_test;
  import rs_pkg::*;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   alloc_valid;
  logic [PORTW-1:0]       alloc_port;
  logic [TAGW-1:0]        alloc_src0_tag, alloc_src1_tag, alloc_dst, wb_tag;
  logic                   alloc_src0_rdy, alloc_src1_rdy, wb_valid, flush_valid;
  logic [SEQW-1:0]        alloc_seq, flush_seq;
  logic                   alloc_ready;
  logic [NPORTS-1:0]      port_busy, issue_valid;
  logic [NPORTS*TAGW-1:0] issue_dst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rs_sched #(.ENTRIES(16), .AGEW(2)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_port(alloc_port),
    .alloc_src0_tag(alloc_src0_tag), .alloc_src0_rdy(alloc_src0_rdy),
    .alloc_src1_tag(alloc_src1_tag), .alloc_src1_rdy(alloc_src1_rdy),
    .alloc_dst(alloc_dst), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .flush_valid(flush_valid),
    .flush_seq(flush_seq), .port_busy(port_busy), .issue_valid(issue_valid),
    .issue_dst(issue_dst)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  function automatic int dst_of(input int p);
    return int'(issue_dst[p*TAGW +: TAGW]);
  endfunction

  task automatic expect_vec(input logic [NPORTS-1:0] exp, input string rq);
    @(negedge clk);
    chk(issue_valid == exp, rq, int'(issue_valid), int'(exp));
  endtask

  task automatic expect_one(input int p, input int d, input string rq);
    @(negedge clk);
    chk(issue_valid == NPORTS'(1 << p), rq, int'(issue_valid), 1 << p);
    chk(dst_of(p) == d, rq, dst_of(p), d);
  endtask

  task automatic do_alloc(input int p, input int t0, input bit r0, input int t1,
                          input bit r1, input int d, input int s);
    alloc_valid    = 1'b1;
    alloc_port     = PORTW'(p);
    alloc_src0_tag = TAGW'(t0);
    alloc_src0_rdy = r0;
    alloc_src1_tag = TAGW'(t1);
    alloc_src1_rdy = r1;
    alloc_dst      = TAGW'(d);
    alloc_seq      = SEQW'(s);
    next_cycle();
    alloc_valid    = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(issue_valid == '0, "R1", int'(issue_valid), 0);
    chk(alloc_ready == 1'b1, "R1", int'(alloc_ready), 1);
  endtask

  task automatic t_basic();
    port_busy = '0;
    do_alloc(2, 1, 1, 2, 1, 5, 1);
    expect_one(2, 5, "R2");
    next_cycle();
    expect_vec('0, "R5");
    next_cycle();
  endtask

  task automatic t_busy_hold();
    port_busy = 5'b00010;
    do_alloc(1, 1, 1, 2, 1, 7, 2);
    expect_vec('0, "R10");
    next_cycle();
    expect_vec('0, "R10");
    next_cycle();
    port_busy = '0;
    expect_one(1, 7, "R10");
    next_cycle();
    expect_vec('0, "R5");
    next_cycle();
  endtask

  task automatic t_wakeup();
    port_busy = '0;
    do_alloc(0, 9, 0, 3, 1, 10, 3);
    expect_vec('0, "R2");
    next_cycle();
    wb_valid = 1'b1; wb_tag = 6'd8;
    expect_vec('0, "R4");
    next_cycle();
    wb_valid = 1'b0;
    expect_vec('0, "R4");
    next_cycle();
    wb_valid = 1'b1; wb_tag = 6'd9;
    expect_vec('0, "R4");
    next_cycle();
    wb_valid = 1'b0;
    expect_one(0, 10, "R4");
    next_cycle();
    expect_vec('0, "R5");
    next_cycle();
    // writeback arriving in the allocation cycle
    wb_valid = 1'b1; wb_tag = 6'd21;
    do_alloc(3, 4, 1, 21, 0, 13, 4);
    wb_valid = 1'b0;
    expect_one(3, 13, "R4");
    next_cycle();
  endtask

  task automatic t_five_ports();
    port_busy = '1;
    for (int p = 0; p < NPORTS; p++) do_alloc(p, 1, 1, 1, 1, 40 + p, 5 + p);
    do_alloc(3, 1, 1, 1, 1, 50, 10);
    port_busy = '0;
    @(negedge clk);
    chk(issue_valid == '1, "R3", int'(issue_valid), 31);
    for (int p = 0; p < NPORTS; p++) chk(dst_of(p) == 40 + p, "R3", dst_of(p), 40 + p);
    next_cycle();
    expect_one(3, 50, "R3");
    next_cycle();
    expect_vec('0, "R5");
    next_cycle();
  endtask

  task automatic t_oldest();
    port_busy = 5'b10000;
    do_alloc(4, 1, 1, 1, 1, 1, 20);
    do_alloc(4, 1, 1, 1, 1, 2, 10);
    port_busy = '0;
    expect_one(4, 1, "R6");
    next_cycle();
    expect_one(4, 2, "R6");
    next_cycle();
    expect_vec('0, "R5");
    next_cycle();
  endtask

  task automatic t_hot();
    port_busy = 5'b00100;
    do_alloc(2, 1, 1, 1, 1, 11, 30);
    do_alloc(2, 33, 0, 1, 1, 12, 31);
    next_cycle();
    wb_valid = 1'b1; wb_tag = 6'd33;
    expect_vec('0, "R7");
    next_cycle();
    wb_valid  = 1'b0;
    port_busy = '0;
    expect_one(2, 12, "R7");
    next_cycle();
    expect_one(2, 11, "R7");
    next_cycle();
    expect_vec('0, "R5");
    next_cycle();
  endtask

  task automatic t_saturate();
    port_busy = 5'b00011;
    do_alloc(1, 1, 1, 1, 1, 60, 40);
    do_alloc(0, 1, 1, 1, 1, 61, 41);
    port_busy = 5'b00001;
    expect_one(1, 60, "R6");
    next_cycle();
    do_alloc(0, 1, 1, 1, 1, 62, 42);
    for (int k = 0; k < 3; k++) next_cycle();
    port_busy = '0;
    expect_one(0, 62, "R6");
    next_cycle();
    expect_one(0, 61, "R6");
    next_cycle();
    expect_vec('0, "R5");
    next_cycle();
  endtask

  task automatic t_full();
    port_busy = 5'b00001;
    for (int i = 0; i < 16; i++) do_alloc(0, 1, 1, 1, 1, i, i);
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R8", int'(alloc_ready), 0);
    next_cycle();
    do_alloc(0, 1, 1, 1, 1, 55, 20);
    port_busy = '0;
    for (int i = 0; i < 16; i++) begin
      expect_one(0, i, "R8");
      next_cycle();
    end
    expect_vec('0, "R8");
    next_cycle();
  endtask

  task automatic t_flush();
    port_busy = 5'b00010;
    do_alloc(1, 1, 1, 1, 1, 1, 5);
    do_alloc(1, 1, 1, 1, 1, 2, 8);
    do_alloc(1, 1, 1, 1, 1, 3, 6);
    do_alloc(1, 1, 1, 1, 1, 4, 63);
    flush_valid = 1'b1; flush_seq = 6'd6;
    alloc_valid = 1'b1; alloc_port = 3'd1; alloc_dst = 6'd50; alloc_seq = 6'd0;
    alloc_src0_rdy = 1'b1; alloc_src1_rdy = 1'b1;
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R9", int'(alloc_ready), 0);
    next_cycle();
    flush_valid = 1'b0; alloc_valid = 1'b0;
    port_busy   = '0;
    expect_one(1, 1, "R9");
    next_cycle();
    expect_one(1, 3, "R9");
    next_cycle();
    expect_one(1, 4, "R9");
    next_cycle();
    expect_vec('0, "R9");
    next_cycle();
    // a ready entry killed by a flush does not issue that cycle
    port_busy = 5'b00100;
    do_alloc(2, 1, 1, 1, 1, 14, 30);
    port_busy = '0;
    flush_valid = 1'b1; flush_seq = 6'd20;
    expect_vec('0, "R9");
    next_cycle();
    flush_valid = 1'b0;
    expect_vec('0, "R9");
    next_cycle();
  endtask

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_port = '0; alloc_src0_tag = '0; alloc_src0_rdy = 1'b0;
    alloc_src1_tag = '0; alloc_src1_rdy = 1'b0; alloc_dst = '0; alloc_seq = '0;
    wb_valid = 1'b0; wb_tag = '0; flush_valid = 1'b0; flush_seq = '0; port_busy = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    next_cycle();
    t_basic();
    t_busy_hold();
    t_wakeup();
    t_five_ports();
    t_oldest();
    t_hot();
    t_saturate();
    t_full();
    t_flush();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule